// File: doc/BRIEF.md
# Block-Aligned Start Detector and Length Extractor

This block serves one region of a multi-region streaming data word. It receives a running byte offset that points just past the end of the previous inner frame of a packed container packet. It rounds that offset up to the next 8-byte block boundary and splits the result into a word number, a region number and a block number. It then decides whether the next inner frame begins inside the region it serves in the current word.

On a match, the block raises a start flag and reads the 16-bit little-endian length that the new frame's header carries in its first two bytes. The region data, metadata, offset, word index and start mask pass through unchanged. All outputs leave through one register stage.

One instance is placed per region of the word, each with its own fixed region index. Several stages of such instances, each with an offset accumulator between them, unpack the inner frames one after another. The accumulator is not part of this block.

Top module: `block_start_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is zero after that edge.
- R2: `out_data`, `out_meta`, `out_offset`, `out_word` and `out_mask` equal the matching inputs of the previous clock cycle.
- R3: The offset is a byte count. It is rounded up to a multiple of 8: an offset that is already a multiple of 8 selects block `offset/8`, and any other offset selects the following block.
- R4: With rounded block count `r`, the selected block within a region is `r mod REGION_BLOCKS`, the selected region is `(r / REGION_BLOCKS) mod REGIONS`, and the selected word is `(r / (REGION_BLOCKS*REGIONS))`. `out_start` is 1 only when the selected word equals `in_word` and the selected region equals `REGION_IDX`.
- R5: When `in_mask` is 0, `out_start` is 0 and `out_length` is 0 in the next cycle, whatever the offset.
- R6: On a start, `out_length` is `{byte[8*b+1], byte[8*b]}`, where `b` is the selected block and byte `k` is `in_data[8*k+7:8*k]`. The lower-addressed byte is the low half.
- R7: When no start is asserted, `out_length` is zero.
- R8: The selected word is taken modulo `MAX_WORDS`. An offset that rounds up past the last block of the last word selects word 0, region 0, block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | REGION_BLOCKS*64 | Region data, byte k at bits 8k+7..8k |
| in_meta | input | META_W | Metadata carried alongside the data |
| in_offset | input | OFFSET_W | Running byte offset from the word-0 start of the container |
| in_word | input | WORD_W | Index of the current word within the container |
| in_mask | input | 1 | Enables start detection in this region |
| out_data | output | REGION_BLOCKS*64 | Registered data |
| out_meta | output | META_W | Registered metadata |
| out_offset | output | OFFSET_W | Registered offset, unrounded |
| out_word | output | WORD_W | Registered word index |
| out_length | output | 16 | Extracted frame length, zero without a start |
| out_start | output | 1 | New inner frame starts in this region |
| out_mask | output | 1 | Registered start mask |

## Verification
The hardest case to reach is an offset that rounds up across a region or word boundary. Examples are an offset one byte past a block edge that lands in the next region, and an offset near the top of the range that wraps back to word 0. These land on the region a frame would start in only for a narrow set of offset and word pairs. The bench therefore sweeps every offset value against every word index and both mask values. It drives two instances with different region indices from the same inputs, so every rounded location is compared on a region that matches and on one that does not.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int BLOCK_ITEMS = 8;
    localparam int ITEM_W      = 8;
    localparam int BLOCK_BITS  = BLOCK_ITEMS * ITEM_W;
    localparam int LEN_W       = 16;

    // Width of an index field that must be at least one bit.
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

    // Assemble a little-endian 16-bit value from two bytes.
    function automatic logic [LEN_W-1:0] le16(input logic [ITEM_W-1:0] lo,
                                              input logic [ITEM_W-1:0] hi);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/bsd_offset_round.sv
module bsd_offset_round
    import bsd_pkg::*;
#(
    parameter int REGIONS       = 4,
    parameter int REGION_BLOCKS = 8,
    parameter int MAX_WORDS     = 4,
    parameter int OFFSET_W      = 10,
    parameter int BLK_W         = 3,
    parameter int REG_W         = 2,
    parameter int WORD_W        = 2
) (
    input  logic [OFFSET_W-1:0] offset,
    output logic [BLK_W-1:0]    blk,
    output logic [REG_W-1:0]    region,
    output logic [WORD_W-1:0]   word
);
    localparam int SHIFT = $clog2(BLOCK_ITEMS);
    localparam int RND_W = OFFSET_W + 1 - SHIFT;

    logic [OFFSET_W:0]  padded;
    logic [RND_W-1:0]   rounded;

    always_comb begin
        padded  = {1'b0, offset} + (OFFSET_W+1)'(BLOCK_ITEMS - 1);
        rounded = padded[OFFSET_W:SHIFT];
        blk     = BLK_W'(rounded % RND_W'(REGION_BLOCKS));
        region  = REG_W'((rounded / RND_W'(REGION_BLOCKS)) % RND_W'(REGIONS));
        word    = WORD_W'((rounded / RND_W'(REGION_BLOCKS * REGIONS)) % RND_W'(MAX_WORDS));
    end

endmodule

// File: rtl/bsd_len_pick.sv
module bsd_len_pick
    import bsd_pkg::*;
#(
    parameter int REGION_BLOCKS = 8,
    parameter int BLK_W         = 3
) (
    input  logic [REGION_BLOCKS*BLOCK_BITS-1:0] data,
    input  logic [BLK_W-1:0]                    blk,
    output logic [LEN_W-1:0]                    len
);
    logic [LEN_W-1:0] blk_len [REGION_BLOCKS];

    for (genvar g = 0; g < REGION_BLOCKS; g++) begin : g_blk
        assign blk_len[g] = le16(data[g*BLOCK_BITS +: ITEM_W],
                                 data[g*BLOCK_BITS + ITEM_W +: ITEM_W]);
    end

    always_comb begin
        len = '0;
        for (int i = 0; i < REGION_BLOCKS; i++) begin
            if (blk == BLK_W'(i)) len = blk_len[i];
        end
    end

endmodule

// File: rtl/bsd_stage_reg.sv
module bsd_stage_reg
    import bsd_pkg::*;
#(
    parameter int DATA_W   = 512,
    parameter int META_W   = 8,
    parameter int OFFSET_W = 10,
    parameter int WORD_W   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   d_data,
    input  logic [META_W-1:0]   d_meta,
    input  logic [OFFSET_W-1:0] d_offset,
    input  logic [WORD_W-1:0]   d_word,
    input  logic [LEN_W-1:0]    d_length,
    input  logic                d_start,
    input  logic                d_mask,
    output logic [DATA_W-1:0]   q_data,
    output logic [META_W-1:0]   q_meta,
    output logic [OFFSET_W-1:0] q_offset,
    output logic [WORD_W-1:0]   q_word,
    output logic [LEN_W-1:0]    q_length,
    output logic                q_start,
    output logic                q_mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_data   <= '0;
            q_meta   <= '0;
            q_offset <= '0;
            q_word   <= '0;
            q_length <= '0;
            q_start  <= 1'b0;
            q_mask   <= 1'b0;
        end else begin
            q_data   <= d_data;
            q_meta   <= d_meta;
            q_offset <= d_offset;
            q_word   <= d_word;
            q_length <= d_length;
            q_start  <= d_start;
            q_mask   <= d_mask;
        end
    end

endmodule

// File: rtl/block_start_detector.sv
module block_start_detector
    import bsd_pkg::*;
#(
    parameter int REGIONS       = 4,
    parameter int REGION_BLOCKS = 8,
    parameter int MAX_WORDS     = 4,
    parameter int META_W        = 8,
    parameter int HDR_LEN       = 16,
    parameter int REGION_IDX    = 0,
    localparam int DATA_W   = REGION_BLOCKS * BLOCK_BITS,
    localparam int OFFSET_W = $clog2(MAX_WORDS * REGIONS * REGION_BLOCKS * BLOCK_ITEMS),
    localparam int WORD_W   = idx_width(MAX_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   in_data,
    input  logic [META_W-1:0]   in_meta,
    input  logic [OFFSET_W-1:0] in_offset,
    input  logic [WORD_W-1:0]   in_word,
    input  logic                in_mask,
    output logic [DATA_W-1:0]   out_data,
    output logic [META_W-1:0]   out_meta,
    output logic [OFFSET_W-1:0] out_offset,
    output logic [WORD_W-1:0]   out_word,
    output logic [LEN_W-1:0]    out_length,
    output logic                out_start,
    output logic                out_mask
);
    localparam int BLK_W = idx_width(REGION_BLOCKS);
    localparam int REG_W = idx_width(REGIONS);

    if (HDR_LEN < 2) begin : g_bad_hdr
        $error("header must hold the 2-byte length field");
    end

    logic [BLK_W-1:0]  sel_blk;
    logic [REG_W-1:0]  sel_region;
    logic [WORD_W-1:0] sel_word;
    logic [LEN_W-1:0]  picked_len;
    logic              hit;
    logic [LEN_W-1:0]  hit_len;

    bsd_offset_round #(
        .REGIONS(REGIONS), .REGION_BLOCKS(REGION_BLOCKS), .MAX_WORDS(MAX_WORDS),
        .OFFSET_W(OFFSET_W), .BLK_W(BLK_W), .REG_W(REG_W), .WORD_W(WORD_W)
    ) round_i (
        .offset(in_offset), .blk(sel_blk), .region(sel_region), .word(sel_word)
    );

    bsd_len_pick #(
        .REGION_BLOCKS(REGION_BLOCKS), .BLK_W(BLK_W)
    ) pick_i (
        .data(in_data), .blk(sel_blk), .len(picked_len)
    );

    always_comb begin
        hit     = in_mask && (sel_word == in_word) && (sel_region == REG_W'(REGION_IDX));
        hit_len = hit ? picked_len : '0;
    end

    bsd_stage_reg #(
        .DATA_W(DATA_W), .META_W(META_W), .OFFSET_W(OFFSET_W), .WORD_W(WORD_W)
    ) out_i (
        .clk(clk), .rst(rst),
        .d_data(in_data), .d_meta(in_meta), .d_offset(in_offset), .d_word(in_word),
        .d_length(hit_len), .d_start(hit), .d_mask(in_mask),
        .q_data(out_data), .q_meta(out_meta), .q_offset(out_offset), .q_word(out_word),
        .q_length(out_length), .q_start(out_start), .q_mask(out_mask)
    );

    AST_START_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        out_start |-> out_mask);                                      // R5
    AST_IDLE_LEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_start |-> (out_length == '0));                           // R7
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_offset == $past(in_offset)));                   // R2
    AST_WORD_PASS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_word == $past(in_word)));                       // R2
    AST_MASKED_NO_START: assert property (@(posedge clk) disable iff (rst)
        !in_mask |=> !out_start);                                     // R5
    AST_START_WORD_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_start |=> 1'b1 ##0 ($past(out_word) == $past(sel_word, 2)) || $past(rst, 2) || $past(rst)); // R4

endmodule

// File: tb/block_start_detector_tb_top.sv
module block_start_detector_tb_top;

    localparam int REGIONS = 2;
    localparam int RB      = 2;
    localparam int MW      = 4;
    localparam int MW_BITS = 8;
    localparam int DW      = RB * 64;
    localparam int OW      = 7;
    localparam int WW      = 2;

    logic clk = 1'b0;
    logic rst;
    always #10 clk = ~clk;

    logic [DW-1:0]      in_data;
    logic [MW_BITS-1:0] in_meta;
    logic [OW-1:0]      in_offset;
    logic [WW-1:0]      in_word;
    logic               in_mask;

    logic [DW-1:0]      d0_data, d1_data;
    logic [MW_BITS-1:0] d0_meta, d1_meta;
    logic [OW-1:0]      d0_off, d1_off;
    logic [WW-1:0]      d0_word, d1_word;
    logic [15:0]        d0_len, d1_len;
    logic               d0_st, d1_st, d0_mask, d1_mask;

    block_start_detector #(.REGIONS(REGIONS), .REGION_BLOCKS(RB), .MAX_WORDS(MW),
        .META_W(MW_BITS), .HDR_LEN(16), .REGION_IDX(0)) dut_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_meta(in_meta),
        .in_offset(in_offset), .in_word(in_word), .in_mask(in_mask),
        .out_data(d0_data), .out_meta(d0_meta), .out_offset(d0_off), .out_word(d0_word),
        .out_length(d0_len), .out_start(d0_st), .out_mask(d0_mask));

    block_start_detector #(.REGIONS(REGIONS), .REGION_BLOCKS(RB), .MAX_WORDS(MW),
        .META_W(MW_BITS), .HDR_LEN(16), .REGION_IDX(1)) dut_hi_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_meta(in_meta),
        .in_offset(in_offset), .in_word(in_word), .in_mask(in_mask),
        .out_data(d1_data), .out_meta(d1_meta), .out_offset(d1_off), .out_word(d1_word),
        .out_length(d1_len), .out_start(d1_st), .out_mask(d1_mask));

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h (offset %0d word %0d mask %0b)",
                     req, act, exp, in_offset, in_word, in_mask);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int v;
        rst       = 1'b1;
        in_data   = '1;
        in_meta   = '1;
        in_offset = 7'd9;
        in_word   = 2'd0;
        in_mask   = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset holds every output at zero
        chk("R1 data",  d0_data, '0);
        chk("R1 meta",  DW'(d0_meta), '0);
        chk("R1 start", DW'({d0_st, d1_st}), '0);
        chk("R1 len",   DW'({d0_len, d1_len}), '0);
        chk("R1 mask",  DW'({d0_mask, d1_mask}), '0);
        chk("R1 word/off", DW'({d0_word, d0_off}), '0);
        rst = 1'b0;
        v = 0;
        for (int off = 0; off < 128; off++) begin
            for (int w = 0; w < MW; w++) begin
                for (int m = 0; m < 2; m++) begin
                    int r, blk, reg_sel, wd;
                    logic [15:0] exp_len [2];
                    logic exp_st [2];
                    @(negedge clk);
                    for (int k = 0; k < DW/8; k++)
                        in_data[8*k +: 8] = 8'((v * 37 + k * 11 + 5) & 255);
                    in_meta   = 8'((v * 13) & 255);
                    in_offset = OW'(off);
                    in_word   = WW'(w);
                    in_mask   = m[0];
                    // R3 round up to 8-byte block; R4 decompose; R8 word modulo MAX_WORDS
                    r       = (off + 7) / 8;
                    blk     = r % RB;
                    reg_sel = (r / RB) % REGIONS;
                    wd      = (r / (RB * REGIONS)) % MW;
                    for (int i = 0; i < 2; i++) begin
                        exp_st[i]  = (m == 1) && (wd == w) && (reg_sel == i);
                        exp_len[i] = exp_st[i] ?
                            {in_data[(blk*8+1)*8 +: 8], in_data[(blk*8)*8 +: 8]} : 16'd0;
                    end
                    @(negedge clk);
                    chk("R2 data",   d0_data, in_data);
                    chk("R2 meta",   DW'(d1_meta), DW'(in_meta));
                    chk("R2 offset", DW'({d0_off, d1_off}), DW'({in_offset, in_offset}));
                    chk("R2 word",   DW'({d0_word, d1_word}), DW'({in_word, in_word}));
                    chk("R2 mask",   DW'({d0_mask, d1_mask}), DW'({in_mask, in_mask}));
                    // R4 R5 R8 start flag per region index
                    chk("R4 start region0", DW'(d0_st), DW'(exp_st[0]));
                    chk("R4 start region1", DW'(d1_st), DW'(exp_st[1]));
                    // R6 little-endian length, R7 zero without start
                    chk(exp_st[0] ? "R6 length region0" : "R7 length region0",
                        DW'(d0_len), DW'(exp_len[0]));
                    chk(exp_st[1] ? "R6 length region1" : "R7 length region1",
                        DW'(d1_len), DW'(exp_len[1]));
                    v++;
                end
            end
        end
        // R1: reset asserted mid-run clears a live start
        @(negedge clk);
        in_offset = 7'd0; in_word = 2'd0; in_mask = 1'b1;
        @(negedge clk);
        chk("R3 exact multiple start", DW'(d0_st), DW'(1));
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run start", DW'({d0_st, d1_st}), '0);
        chk("R1 mid-run len",   DW'({d0_len, d1_len}), '0);
        summary();
    end

endmodule